// File: doc/BRIEF.md
# Break Instruction Execute Unit

This execute-stage block carries out the two software break instructions of a 32-bit soft processor. One form takes its target from a register and the other from an immediate. The block also handles a hardware break request raised from outside the pipeline. Each cycle it reads the instruction word and its operands, with the status register and the vector base. One cycle later it presents the result: a program-counter redirect, a link-register write, an updated status word, a strobe that drops any load-reserve reservation, or a privilege trap request when user code may not run the instruction.

A break sets a break-in-progress flag in the status word. The system-call and debug vectors also move the live user-mode and virtual-mode bits into their saved positions and clear the live bits. A hardware break is treated as a debug entry. It links the current PC into register 16 and jumps to the vector base plus 0x18. When a hardware break and an instruction arrive together, the hardware break wins.

Top module: `brk_exec_unit`

## Requirements
- R1: An instruction is taken only when `in_valid` is high and it decodes as one of two forms. The register form has bits [31:26]=100110, bits [20:16]=01100 and bits [10:0]=0. The immediate form has bits [31:26]=101110 and bits [20:16]=01100. Any other word leaves every output strobe low.
- R2: All outputs are registered. The result for the inputs sampled at one rising edge is visible right after that edge, and the strobes are single-cycle.
- R3: An executed break asserts `pc_redirect`. The target is `rb_val` for the register form and `imm_sext` for the immediate form.
- R4: With rd (bits [25:21]) nonzero, an executed break writes `next_pc` to register rd. With rd zero, `rf_we` stays low.
- R5: An executed instruction break asserts `resv_clr`.
- R6: With user mode set (status bit 11), the register form always traps. The immediate form traps unless `imm_sext` is 0x8 or 0x18.
- R7: A privilege trap asserts only `priv_trap`. No redirect, register write, status write or reservation clear happens in that cycle.
- R8: An executed break sets the break-in-progress flag (status bit 3). The one exception is the immediate form with value 0x18, which leaves bit 3 as it was.
- R9: For immediates 0x8 and 0x18, bit 11 is copied to bit 12 and bit 13 to bit 14, then bits 11 and 13 are cleared. Every other break leaves those four bits alone. All bits other than 3 and 11-14 pass through unchanged.
- R10: `hw_brk_req` takes priority over any instruction. It writes `cur_pc` to register 16, redirects to `vec_base`+0x18, sets bit 3, does the R9 save-and-clear of the mode bits, does not clear the reservation and never traps.
- R11: While `rst_n` is low, every output reads zero after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| next_pc | input | 32 | Address of the next sequential instruction |
| rb_val | input | 32 | Value of the rb operand register |
| imm_sext | input | 32 | Sign-extended immediate |
| msr_in | input | 32 | Current machine status register |
| vec_base | input | 32 | Base address of the vector table |
| cur_pc | input | 32 | Address of the current instruction |
| hw_brk_req | input | 1 | External hardware break request |
| pc_redirect | output | 1 | Program counter redirect strobe |
| pc_target | output | 32 | Redirect address |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| msr_we | output | 1 | Status register write strobe |
| msr_out | output | 32 | New status register value |
| resv_clr | output | 1 | Drop the load-reserve reservation |
| priv_trap | output | 1 | Privilege trap request |

## Verification
Two of this block's functions can fall in the same cycle: a hardware break request and a decodable break instruction. The same goes for a user-mode break that is both privileged and carries a mode-saving vector. The bench drives `hw_brk_req` together with both instruction forms, in kernel and user mode, and with a trapping user-mode word. It expects the vector-base jump, the link to register 16 and no trap or reservation clear. A behavioural reference model judges every cycle, over directed cases and a long stream of random mixes of the two functions.

// File: rtl/brk_pkg.sv
// Package brk_pkg
// Shared constants and the registered result bundle of the break execute unit.
// Assumes a 32-bit datapath and 5-bit register indices.
package brk_pkg;
    localparam int XLEN       = 32;
    localparam int RIDX_W     = 5;

    // Status register bit positions
    localparam int ST_BIP     = 3;
    localparam int ST_UM      = 11;
    localparam int ST_UMS     = 12;
    localparam int ST_VM      = 13;
    localparam int ST_VMS     = 14;
    localparam int MODE_PAIRS = 2;

    // Instruction encoding
    localparam logic [5:0] OPC_REG_BRK = 6'b100110;
    localparam logic [5:0] OPC_IMM_BRK = 6'b101110;
    localparam logic [4:0] SUBOP_BRK   = 5'b01100;

    // Vectors
    localparam logic [XLEN-1:0] VEC_SYSCALL = 32'h0000_0008;
    localparam logic [XLEN-1:0] VEC_DEBUG   = 32'h0000_0018;
    localparam logic [RIDX_W-1:0] HW_LINK_REG = 5'd16;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_REG  = 2'd1,
        KIND_IMM  = 2'd2
    } brk_kind_e;

    typedef struct packed {
        logic              redirect;
        logic [XLEN-1:0]   target;
        logic              rf_we;
        logic [RIDX_W-1:0] waddr;
        logic [XLEN-1:0]   wdata;
        logic              msr_we;
        logic [XLEN-1:0]   msr;
        logic              resv_clr;
        logic              trap;
    } brk_result_t;
endpackage

// File: rtl/brk_decode.sv
// Module brk_decode
// Recognises the register and immediate break forms and extracts rd.
// Assumes the caller qualifies the word with a valid strobe.
module brk_decode
    import brk_pkg::*;
(
    input  logic              valid_i,
    input  logic [XLEN-1:0]   instr_i,
    output brk_kind_e         kind_o,
    output logic [RIDX_W-1:0] rd_o
);
    logic is_reg;
    logic is_imm;
    logic unused_rb_field;

    assign unused_rb_field = ^instr_i[15:11];

    // Match the two encodings; the register form must have its low field zero
    always_comb begin
        is_reg = valid_i && (instr_i[31:26] == OPC_REG_BRK)
                 && (instr_i[20:16] == SUBOP_BRK) && (instr_i[10:0] == 11'd0);
        is_imm = valid_i && (instr_i[31:26] == OPC_IMM_BRK)
                 && (instr_i[20:16] == SUBOP_BRK);
        kind_o = is_reg ? KIND_REG : (is_imm ? KIND_IMM : KIND_NONE);
        rd_o   = instr_i[25:21];
    end
endmodule

// File: rtl/brk_status.sv
// Module brk_status
// Builds the new status word: optional save-and-clear of the mode bit pairs
// and optional setting of the break-in-progress flag.
// Assumes each saved bit sits directly above its live bit.
module brk_status
    import brk_pkg::*;
(
    input  logic [XLEN-1:0] msr_i,
    input  logic            set_bip_i,
    input  logic            save_modes_i,
    output logic [XLEN-1:0] msr_o
);
    localparam int LIVE_POS [MODE_PAIRS] = '{ST_UM, ST_VM};

    logic [XLEN-1:0] save_mask;
    logic [XLEN-1:0] save_val;

    // One mask term and one copied bit per mode pair
    for (genvar g = 0; g < MODE_PAIRS; g++) begin : g_pair
        logic [XLEN-1:0] pair_mask;
        logic [XLEN-1:0] pair_val;
        always_comb begin
            pair_mask = '0;
            pair_val  = '0;
            pair_mask[LIVE_POS[g]]   = 1'b1;
            pair_mask[LIVE_POS[g]+1] = 1'b1;
            pair_val[LIVE_POS[g]+1]  = msr_i[LIVE_POS[g]];
        end
    end

    // Combine the per-pair terms
    always_comb begin
        save_mask = '0;
        save_val  = '0;
        save_mask = g_pair[0].pair_mask | g_pair[1].pair_mask;
        save_val  = g_pair[0].pair_val  | g_pair[1].pair_val;
    end

    // Apply the save-and-clear, then the flag
    always_comb begin
        msr_o = save_modes_i ? ((msr_i & ~save_mask) | save_val) : msr_i;
        if (set_bip_i) begin
            msr_o[ST_BIP] = 1'b1;
        end
    end
endmodule

// File: rtl/brk_exec_unit.sv
// Module brk_exec_unit
// Execute stage for the break instructions and the hardware break request.
// Produces registered redirect, link write, status write, reservation clear
// and privilege trap one cycle after the inputs are sampled.
// Assumes imm_sext already holds any immediate-prefix extension.
module brk_exec_unit
    import brk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [31:0]          instr,
    input  logic [31:0]          next_pc,
    input  logic [31:0]          rb_val,
    input  logic [31:0]          imm_sext,
    input  logic [31:0]          msr_in,
    input  logic [31:0]          vec_base,
    input  logic [31:0]          cur_pc,
    input  logic                 hw_brk_req,
    output logic                 pc_redirect,
    output logic [31:0]          pc_target,
    output logic                 rf_we,
    output logic [4:0]           rf_waddr,
    output logic [31:0]          rf_wdata,
    output logic                 msr_we,
    output logic [31:0]          msr_out,
    output logic                 resv_clr,
    output logic                 priv_trap
);
    brk_kind_e         kind;
    logic [RIDX_W-1:0] rd;
    logic              vec_ok;
    logic              is_debug_vec;
    logic              set_bip;
    logic              save_modes;
    logic [XLEN-1:0]   msr_new;
    brk_result_t       nxt;
    brk_result_t       res_q;

    brk_decode u_dec (
        .valid_i (in_valid),
        .instr_i (instr),
        .kind_o  (kind),
        .rd_o    (rd)
    );

    // Classify the immediate and choose the status-update options
    always_comb begin
        is_debug_vec = (imm_sext == VEC_DEBUG);
        vec_ok       = is_debug_vec || (imm_sext == VEC_SYSCALL);
        set_bip      = hw_brk_req || (kind == KIND_REG) || !is_debug_vec;
        save_modes   = hw_brk_req || ((kind == KIND_IMM) && vec_ok);
    end

    brk_status u_st (
        .msr_i        (msr_in),
        .set_bip_i    (set_bip),
        .save_modes_i (save_modes),
        .msr_o        (msr_new)
    );

    // Select the result: hardware break first, then trap or executed break
    always_comb begin
        nxt = '0;
        if (hw_brk_req) begin
            nxt.redirect = 1'b1;
            nxt.target   = vec_base + VEC_DEBUG;
            nxt.rf_we    = 1'b1;
            nxt.waddr    = HW_LINK_REG;
            nxt.wdata    = cur_pc;
            nxt.msr_we   = 1'b1;
            nxt.msr      = msr_new;
        end else if (kind != KIND_NONE) begin
            if (msr_in[ST_UM] && ((kind == KIND_REG) || !vec_ok)) begin
                nxt.trap = 1'b1;
            end else begin
                nxt.redirect = 1'b1;
                nxt.target   = (kind == KIND_REG) ? rb_val : imm_sext;
                nxt.rf_we    = (rd != '0);
                nxt.waddr    = (rd != '0) ? rd : '0;
                nxt.wdata    = (rd != '0) ? next_pc : '0;
                nxt.msr_we   = 1'b1;
                nxt.msr      = msr_new;
                nxt.resv_clr = 1'b1;
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= nxt;
        end
    end

    assign pc_redirect = res_q.redirect;
    assign pc_target   = res_q.target;
    assign rf_we       = res_q.rf_we;
    assign rf_waddr    = res_q.waddr;
    assign rf_wdata    = res_q.wdata;
    assign msr_we      = res_q.msr_we;
    assign msr_out     = res_q.msr;
    assign resv_clr    = res_q.resv_clr;
    assign priv_trap   = res_q.trap;

    AST_TRAP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        priv_trap |-> !pc_redirect && !rf_we && !msr_we && !resv_clr); // R7
    AST_LINK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_waddr != 5'd0); // R4
    AST_RESV_WITH_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clr |-> pc_redirect && msr_we); // R5
    AST_NO_BIP_CLEARS_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_we && !msr_out[ST_BIP]) |-> !msr_out[ST_UM] && !msr_out[ST_VM]); // R9
    AST_HW_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hw_brk_req)) |->
        pc_redirect && !priv_trap && !resv_clr
        && (pc_target == $past(vec_base) + 32'h18) && (rf_waddr == 5'd16)); // R10
endmodule

// File: tb/brk_exec_unit_tb.sv
`timescale 1ns/1ps
module brk_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr, next_pc, rb_val, imm_sext, msr_in, vec_base, cur_pc;
    logic        hw_brk_req;
    logic        pc_redirect, rf_we, msr_we, resv_clr, priv_trap;
    logic [31:0] pc_target, rf_wdata, msr_out;
    logic [4:0]  rf_waddr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    brk_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .next_pc(next_pc), .rb_val(rb_val), .imm_sext(imm_sext),
        .msr_in(msr_in), .vec_base(vec_base), .cur_pc(cur_pc),
        .hw_brk_req(hw_brk_req), .pc_redirect(pc_redirect),
        .pc_target(pc_target), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .msr_we(msr_we), .msr_out(msr_out),
        .resv_clr(resv_clr), .priv_trap(priv_trap)
    );

    function automatic logic [31:0] mk_brk(input int rd, input int rb);
        return {6'b100110, 5'(rd), 5'b01100, 5'(rb), 11'd0};
    endfunction

    function automatic logic [31:0] mk_brki(input int rd, input logic [15:0] imm);
        return {6'b101110, 5'(rd), 5'b01100, imm};
    endfunction

    // Behavioural reference: returns the 106-bit output bundle
    function automatic logic [105:0] model();
        logic red = 0, we = 0, mwe = 0, rc = 0, tr = 0;
        logic [31:0] tgt = 0, wd = 0, m = 0;
        logic [4:0] wa = 0;
        bit reg_form, imm_form, mode_save, bip;
        reg_form = in_valid && instr[31:26] == 6'h26 && instr[20:16] == 5'h0C
                   && instr[10:0] == 0;
        imm_form = in_valid && instr[31:26] == 6'h2E && instr[20:16] == 5'h0C;
        if (!rst_n) return '0;
        m = msr_in;
        if (hw_brk_req) begin
            red = 1; tgt = vec_base + 32'h18; we = 1; wa = 16; wd = cur_pc;
            mwe = 1; mode_save = 1; bip = 1;
        end else if (reg_form || imm_form) begin
            if (msr_in[11] && (reg_form || (imm_sext != 8 && imm_sext != 24))) begin
                tr = 1;
                return {red, tgt, we, wa, wd, mwe, 32'd0, rc, tr};
            end
            red = 1; tgt = reg_form ? rb_val : imm_sext;
            if (instr[25:21] != 0) begin we = 1; wa = instr[25:21]; wd = next_pc; end
            mwe = 1; rc = 1;
            mode_save = imm_form && (imm_sext == 8 || imm_sext == 24);
            bip = reg_form || imm_sext != 24;
        end else begin
            return '0;
        end
        if (mode_save) begin
            m[12] = msr_in[11]; m[14] = msr_in[13]; m[11] = 0; m[13] = 0;
        end
        if (bip) m[3] = 1;
        return {red, tgt, we, wa, wd, mwe, m, rc, tr};
    endfunction

    // One clock: compute expectation, pass an edge, compare away from it
    task automatic step(input string tag);
        logic [105:0] exp_v, act_v;
        exp_v = model();
        @(posedge clk);
        @(negedge clk);
        act_v = {pc_redirect, pc_target, rf_we, rf_waddr, rf_wdata, msr_we,
                 msr_out, resv_clr, priv_trap};
        n_tests++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 0; instr = 0; next_pc = 32'h104; rb_val = 32'h2000;
        imm_sext = 0; msr_in = 0; vec_base = 32'h8000_0000; cur_pc = 32'h100;
        hw_brk_req = 0;
    endtask

    task automatic load_imm(input int rd, input logic [15:0] imm);
        instr = mk_brki(rd, imm);
        imm_sext = {{16{imm[15]}}, imm};
        in_valid = 1;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        hw_brk_req = 1; in_valid = 1; instr = mk_brk(3, 4);
        step("R11 reset");
        step("R11 reset hold");
        rst_n = 1;
        idle_inputs();
        step("R1 idle");

        // R3 R4 R5 R8: register form in kernel mode
        in_valid = 1; instr = mk_brk(5, 7); rb_val = 32'h0000_4444; msr_in = 32'h0000_2001;
        step("R3 R4 R5 R8 reg form");
        instr = mk_brk(0, 7);
        step("R4 rd zero no write");
        // R1 malformed words
        instr = mk_brk(5, 7) | 32'h0000_0001;
        step("R1 low bits set");
        instr = mk_brk(5, 7) ^ 32'h0001_0000;
        step("R1 wrong sub-op");
        instr = mk_brk(5, 7); in_valid = 0;
        step("R1 not valid");

        // R9 immediate vectors
        msr_in = 32'h0000_2000; load_imm(9, 16'h0008);
        step("R9 syscall vector kernel");
        msr_in = 32'h0000_A808; load_imm(2, 16'h0018);
        step("R6 R8 R9 debug vector user");
        msr_in = 32'h0000_0000; load_imm(2, 16'h0018);
        step("R8 debug vector no flag");
        msr_in = 32'h0000_2000; load_imm(1, 16'h0000);
        step("R9 other vector keeps modes");
        load_imm(1, 16'hFFF0);
        step("R3 negative immediate");

        // R6 R7 user-mode traps
        msr_in = 32'h0000_0800; load_imm(4, 16'h0010);
        step("R6 R7 user imm trap");
        msr_in = 32'h0000_0800; load_imm(4, 16'h0008);
        step("R6 user syscall allowed");
        instr = mk_brk(4, 1);
        step("R6 R7 user reg trap");

        // R10 hardware break alone and colliding
        idle_inputs(); msr_in = 32'h0000_2800; hw_brk_req = 1; cur_pc = 32'h0000_1230;
        step("R10 hw break");
        in_valid = 1; instr = mk_brk(6, 2); msr_in = 32'h0000_0000;
        step("R10 hw beats reg form");
        msr_in = 32'h0000_0800; instr = mk_brk(6, 2);
        step("R10 hw beats user trap");
        hw_brk_req = 0;
        step("R2 single-cycle after hw");
        idle_inputs();
        step("R2 strobes drop");

        // R2 random stream of mixed stimulus
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom_range(0, 5);
            in_valid = ($urandom_range(0, 7) != 0);
            rb_val = $urandom; next_pc = $urandom; cur_pc = $urandom;
            vec_base = $urandom;
            msr_in = $urandom;
            hw_brk_req = ($urandom_range(0, 5) == 0);
            case (sel)
                0: instr = mk_brk($urandom_range(0, 31), $urandom_range(0, 31));
                1: load_imm($urandom_range(0, 31), 16'h0008);
                2: load_imm($urandom_range(0, 31), 16'h0018);
                3: load_imm($urandom_range(0, 31), 16'($urandom));
                default: begin instr = $urandom; imm_sext = $urandom; end
            endcase
            step("R2 random mix");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule